// File: doc/BRIEF.md
# Eight-Source Interrupt Controller

This block gathers interrupt requests from eight on-chip sources: two external interrupt pins, two timers, an A/D converter, a watchdog, a basic interval timer and a serial port. Each source raises a one-cycle pulse. The block holds that pulse in a request flag until software or the CPU clears it. Every source also has an enable bit. Enables and flags sit in the upper nibble of four byte-wide registers on the internal 8-bit bus. The lower nibbles are not implemented.

A global master enable gates the request to the CPU. Single-cycle strobes represent the CPU's enable-interrupts, disable-interrupts, accept and return-from-interrupt events. When the CPU accepts an interrupt, the master flag drops and the winning request flag is cleared. On return, the master flag comes back. A fixed priority picks one index among the pending, enabled sources and presents it on a 3-bit vector output. A separate wake output releases the chip from STOP mode whenever any enabled request is pending, whatever the state of the master flag.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset, all enables, request flags and the master flag are 0. `cpu_irq`, `wake_stop`, `vec_idx` and `bus_rdata` are also 0.
- R2: The enable registers sit at 0xE2 and 0xE3. In 0xE2, bits 7,6,5,4 enable sources 0,1,2,3 (external 0, external 1, timer 0, timer 1). In 0xE3, bits 7,6,5,4 enable sources 4,5,6,7 (A/D, watchdog, interval timer, serial). A 1 enables a source. Bits 3..0 of every register read 0, and writes to them are ignored.
- R3: A one-cycle pulse on `src_pulse[i]` sets request flag i. The flags read back at 0xE4 (sources 0..3) and 0xE5 (sources 4..7), in the same bit positions as the enables.
- R4: Writing 0 to a request bit clears that flag, and writing 1 has no effect. A source pulse in the same cycle as a clearing write leaves the flag set.
- R5: `ev_ei` sets the master flag and `ev_di` clears it. When both arrive in the same cycle, the flag ends up 0.
- R6: `cpu_irq` is 1 one cycle after a state in which the master flag is 1 and some request is both pending and enabled. Otherwise `cpu_irq` is 0.
- R7: `vec_idx` carries the lowest-numbered pending, enabled source, so source 0 has the highest priority.
- R8: `ev_accept` clears the master flag. While `cpu_irq` is 1, it also clears the request flag named by `vec_idx`. While `cpu_irq` is 0, it clears no request flag.
- R9: `ev_reti` sets the master flag, unless `ev_accept` or `ev_di` arrives in the same cycle.
- R10: `wake_stop` is 1 one cycle after any request is pending and enabled, whatever the master flag.
- R11: `bus_rdata` shows, one cycle later, the register selected by `bus_addr`. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| src_pulse | input | 8 | Per-source request pulses, bit i is source i |
| ev_ei | input | 1 | Enable-interrupts strobe |
| ev_di | input | 1 | Disable-interrupts strobe |
| ev_accept | input | 1 | CPU accepts the presented interrupt |
| ev_reti | input | 1 | Return-from-interrupt strobe |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_idx | output | 3 | Index of the winning source |
| wake_stop | output | 1 | STOP-mode release |
| master_en | output | 1 | Current master enable flag |

## Verification
The assertions assume that every source pulse lasts exactly one cycle. They also assume that `ev_accept` is issued only once per accepted interrupt, in a cycle where `cpu_irq` is visible. The accept-clears-master property holds for any event mix, because accept outranks every setting event. The bench drives all inputs on the falling edge and holds each strobe for a single cycle. It issues accept only after the registered request has settled, with one extra check of accept while no request is shown.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BUS_W      = 8;
  localparam int SRC_PER_REG = BUS_W / 2;
  localparam int SRC_COUNT  = 2 * SRC_PER_REG;
  localparam int IDX_W      = $clog2(SRC_COUNT);
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] EN_HI_ADR = 8'hE2,
  parameter logic [ADDR_W-1:0] EN_LO_ADR = 8'hE3,
  parameter logic [ADDR_W-1:0] RQ_HI_ADR = 8'hE4,
  parameter logic [ADDR_W-1:0] RQ_LO_ADR = 8'hE5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_we,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [SRC_COUNT-1:0] src_pulse,
  input  logic                 ev_ei,
  input  logic                 ev_di,
  input  logic                 ev_accept,
  input  logic                 ev_reti,
  output logic                 cpu_irq,
  output logic [IDX_W-1:0]     vec_idx,
  output logic                 wake_stop,
  output logic                 master_en
);
  localparam int PER  = SRC_PER_REG;
  localparam int NSRC = SRC_COUNT;
  localparam int IW   = IDX_W;

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] pend;
  logic            pend_any;
  logic [IW-1:0]   pend_idx;
  logic            mie_q;
  logic [PER-1:0]  unused_low_wdata;

  assign unused_low_wdata = bus_wdata[PER-1:0];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int                K      = i % PER;
    localparam int                POS    = BUS_W - 1 - K;
    localparam logic [ADDR_W-1:0] EN_ADR = (i < PER) ? EN_HI_ADR : EN_LO_ADR;
    localparam logic [ADDR_W-1:0] RQ_ADR = (i < PER) ? RQ_HI_ADR : RQ_LO_ADR;

    always_ff @(posedge clk) begin
      if (rst)                              en_q[i] <= 1'b0;
      else if (bus_we && bus_addr == EN_ADR) en_q[i] <= bus_wdata[POS];
    end

    assign clr_vec[i] = (bus_we && bus_addr == RQ_ADR && !bus_wdata[POS])
                      || (ev_accept && cpu_irq && vec_idx == IW'(i));
  end

  irq_req_bank #(.N(NSRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (src_pulse),
    .clr_i  (clr_vec),
    .flag_o (flag_q)
  );

  assign pend = flag_q & en_q;

  irq_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
    .req_i (pend),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  always_ff @(posedge clk) begin
    if (rst)                    mie_q <= 1'b0;
    else if (ev_accept || ev_di) mie_q <= 1'b0;
    else if (ev_ei || ev_reti)   mie_q <= 1'b1;
  end
  assign master_en = mie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      vec_idx   <= '0;
      wake_stop <= 1'b0;
    end else begin
      cpu_irq   <= mie_q && pend_any;
      vec_idx   <= pend_idx;
      wake_stop <= pend_any;
    end
  end

  logic [BUS_W-1:0] en_hi_b, en_lo_b, rq_hi_b, rq_lo_b;
  always_comb begin
    en_hi_b = '0;
    en_lo_b = '0;
    rq_hi_b = '0;
    rq_lo_b = '0;
    for (int k = 0; k < PER; k++) begin
      en_hi_b[BUS_W-1-k] = en_q[k];
      en_lo_b[BUS_W-1-k] = en_q[PER+k];
      rq_hi_b[BUS_W-1-k] = flag_q[k];
      rq_lo_b[BUS_W-1-k] = flag_q[PER+k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_addr == EN_HI_ADR) bus_rdata <= en_hi_b;
    else if (bus_addr == EN_LO_ADR) bus_rdata <= en_lo_b;
    else if (bus_addr == RQ_HI_ADR) bus_rdata <= rq_hi_b;
    else if (bus_addr == RQ_LO_ADR) bus_rdata <= rq_lo_b;
    else bus_rdata <= '0;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NSRC  = 8,
  parameter int IW    = 3,
  parameter int BUS_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_pulse,
  input logic            ev_ei,
  input logic            ev_di,
  input logic            ev_accept,
  input logic            ev_reti,
  input logic            cpu_irq,
  input logic [IW-1:0]   vec_idx,
  input logic            wake_stop,
  input logic            master_en,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_d;
  logic            mie_d;
  logic            unused_ev;
  assign unused_ev = ev_ei;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_d <= '0;
      mie_d  <= 1'b0;
    end else begin
      pend_d <= pend;
      mie_d  <= master_en;
    end
  end

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> mie_d); // R6
  AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> wake_stop); // R10
  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    wake_stop |-> pend_d[vec_idx]); // R7
  AST_ACCEPT_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> !master_en); // R8
  AST_RETI_RAISES_MASTER: assert property (@(posedge clk) disable iff (rst)
    (ev_reti && !ev_accept && !ev_di) |=> master_en); // R9
  AST_DI_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
    ev_di |=> !master_en); // R5
  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W/2-1:0] == '0); // R2

  for (genvar i = 0; i < NSRC; i++) begin : g_set
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
      src_pulse[i] |=> flag_q[i]); // R3
  end
endmodule

bind irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .IW(IW), .BUS_W(irq_pkg::BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_pulse (src_pulse),
  .ev_ei     (ev_ei),
  .ev_di     (ev_di),
  .ev_accept (ev_accept),
  .ev_reti   (ev_reti),
  .cpu_irq   (cpu_irq),
  .vec_idx   (vec_idx),
  .wake_stop (wake_stop),
  .master_en (master_en),
  .bus_rdata (bus_rdata),
  .flag_q    (flag_q),
  .pend      (pend)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] src_pulse = '0;
  logic       ev_ei = 0, ev_di = 0, ev_accept = 0, ev_reti = 0;
  logic       cpu_irq;
  logic [2:0] vec_idx;
  logic       wake_stop;
  logic       master_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
    .ev_ei(ev_ei), .ev_di(ev_di), .ev_accept(ev_accept), .ev_reti(ev_reti),
    .cpu_irq(cpu_irq), .vec_idx(vec_idx), .wake_stop(wake_stop),
    .master_en(master_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    step();
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    src_pulse = m;
    step();
    src_pulse = '0;
  endtask

  task automatic ev(input bit e, input bit d, input bit a, input bit r);
    ev_ei = e; ev_di = d; ev_accept = a; ev_reti = r;
    step();
    ev_ei = 0; ev_di = 0; ev_accept = 0; ev_reti = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cpu_irq", cpu_irq, 0);
    chk("R1 wake", wake_stop, 0);
    chk("R1 master", master_en, 0);
    chk("R1 vec", vec_idx, 0);
    bus_rd(8'hE2, d); chk("R1 en_hi", d, 0);
    bus_rd(8'hE5, d); chk("R1 rq_lo", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    bus_wr(8'hE2, 8'hFF);
    bus_rd(8'hE2, d); chk("R2 en_hi readback", d, 8'hF0);
    bus_wr(8'hE3, 8'hA5);
    bus_rd(8'hE3, d); chk("R2 en_lo readback", d, 8'hA0);
    bus_rd(8'h10, d); chk("R11 unmapped", d, 8'h00);
    bus_wr(8'hE2, 8'h00);
    bus_wr(8'hE3, 8'h00);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    pulse(8'b0000_0010);
    bus_rd(8'hE4, d); chk("R3 ext1 flag", d, 8'h40);
    pulse(8'b1000_0000);
    bus_rd(8'hE5, d); chk("R3 serial flag", d, 8'h10);
    chk("R10 disabled no wake", wake_stop, 0);
    bus_wr(8'hE4, 8'hFF);
    bus_rd(8'hE4, d); chk("R4 write one no effect", d, 8'h40);
    bus_wr(8'hE4, 8'h00);
    bus_rd(8'hE4, d); chk("R4 write zero clears", d, 8'h00);
    bus_addr = 8'hE5; bus_wdata = 8'h00; bus_we = 1'b1; src_pulse = 8'h80;
    step();
    bus_we = 1'b0; src_pulse = '0;
    bus_rd(8'hE5, d); chk("R4 pulse beats clear", d, 8'h10);
    bus_wr(8'hE5, 8'h00);
    bus_rd(8'hE5, d); chk("R4 cleared lo", d, 8'h00);
  endtask

  task automatic t_master();
    ev(1, 0, 0, 0); chk("R5 ei sets", master_en, 1);
    ev(0, 1, 0, 0); chk("R5 di clears", master_en, 0);
    ev(1, 1, 0, 0); chk("R5 di wins", master_en, 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    bus_wr(8'hE2, 8'hF0);
    bus_wr(8'hE3, 8'hF0);
    step();
    chk("R6 no pending", cpu_irq, 0);
    pulse(8'b0000_1000);
    step();
    chk("R10 wake without master", wake_stop, 1);
    chk("R6 masked by master", cpu_irq, 0);
    ev(1, 0, 0, 0);
    step();
    chk("R6 irq raised", cpu_irq, 1);
    chk("R7 vec timer1", vec_idx, 3);
    pulse(8'b0010_0100);
    step();
    chk("R7 vec timer0 wins", vec_idx, 2);
    bus_wr(8'hE2, 8'hD0);
    step();
    chk("R7 vec after disable", vec_idx, 3);
    bus_wr(8'hE2, 8'hC0);
    step();
    chk("R7 vec watchdog", vec_idx, 5);
    ev(0, 0, 1, 0);
    chk("R8 master cleared", master_en, 0);
    bus_rd(8'hE5, d); chk("R8 winner flag cleared", d, 8'h00);
    bus_rd(8'hE4, d); chk("R8 others kept", d, 8'h30);
    chk("R8 irq drops", cpu_irq, 0);
    bus_wr(8'hE2, 8'hD0);
    ev(0, 0, 0, 1);
    step();
    chk("R9 reti master", master_en, 1);
    chk("R9 irq again", cpu_irq, 1);
    chk("R9 vec", vec_idx, 3);
    ev(0, 1, 0, 0);
    step();
    chk("R6 di drops irq", cpu_irq, 0);
    ev(0, 0, 1, 0);
    bus_rd(8'hE4, d); chk("R8 idle accept keeps flags", d, 8'h30);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_regs();
    t_flags();
    t_master();
    t_irq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule